// File: doc/BRIEF.md
# Daisy-Chained Readout Enable Controller

This block manages one chip's place in a chain of chips that share a high-speed readout path. An active-low enable token arrives from the upstream chip and an active-low token leaves towards the downstream chip. While the chip's readout is switched off, the token runs straight through with no clocked delay. While it is switched on, the chip holds the token. It streams a programmed number of 16-bit words from the trigger snapshot held by a neighbouring capture block, oldest word first. It then releases the token downstream once its word counter reaches the programmed terminal count.

A small host register window sets the terminal count and the enable bit, and shows the word counter and the live chain state. The snapshot arrives as one flat vector of eight half-words. Half-word h sits at bits 16h+15..16h. Half-words 0 and 1 are the low and high halves of the oldest tick, and half-words 6 and 7 are the low and high halves of the triggered tick. The token goes back to idle when the upstream enable is withdrawn. The block is then ready for the next event.

Top module: `chain_readout_ctl`

## Requirements
- R1: After reset the terminal-count register reads 0, readout is off, `ro_valid` is 0, the current count reads 0, and `chain_out_n` follows `chain_in_n`.
- R2: With the enable bit (bit 15 of address 25) at 0, `chain_out_n` equals `chain_in_n` in the same cycle and `ro_valid` never asserts.
- R3: With the enable bit at 1 and a nonzero terminal count N, the clock edge that first samples `chain_in_n` low while idle starts a burst. `ro_valid` is high for exactly N consecutive cycles, starting the cycle after that edge. State bit 2 reads 1 during the burst.
- R4: Word k of a burst (k from 0) carries snapshot half-word (k mod 8), so the oldest data leaves first and counts above 8 wrap around.
- R5: `chain_out_n` stays high during the burst. It goes low in the cycle after the last word, when the current count (address 26, bits 3:0) equals N.
- R6: Once low, `chain_out_n` stays low until an edge samples `chain_in_n` high. It returns high one cycle later and the current count returns to 0.
- R7: With the enable bit at 1 and a terminal count of 0, the block behaves as in R2 and sends no data.
- R8: Address 25 keeps only bit 15 and bits 3:0 of a write, and other bits read 0. Address 24 reads {13'b0, data-enable, `chain_out_n`, `chain_in_n`}. Writes to 24 and 26 have no effect. Unmapped addresses read 0.
- R9: If `chain_in_n` is sampled high during a burst, the next cycle has `ro_valid` low, the count at 0 and `chain_out_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Host register address |
| reg_wr | input | 1 | Host write strobe, sampled at the clock edge |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational from `reg_addr` |
| cap_data | input | 128 | Captured snapshot, eight 16-bit half-words, oldest at the bottom |
| chain_in_n | input | 1 | Active-low readout token from the upstream chip |
| chain_out_n | output | 1 | Active-low readout token to the downstream chip |
| ro_valid | output | 1 | Readout word valid |
| ro_data | output | 16 | Readout word |

## Verification
In pass-through mode the outgoing token is combinational, so the bench checks it one nanosecond after driving `chain_in_n`. The first word is due in the cycle after the edge that samples the token low. The bench drives inputs just after a rising edge and samples every output on the falling edge, so each result is read one full edge after its cause. The last word, counted from that first edge, is followed one cycle later by the outgoing token and the count equal to N. The token is released one cycle after the edge that sees `chain_in_n` high, so the bench checks it still low before that edge and high after it. Expected words go into a queue when a burst is started, and the monitor pops one per valid cycle, so a missing, extra or misordered word shows as a mismatch or a leftover.

// File: rtl/chain_readout_ctl.sv
module chain_readout_ctl #(
  parameter int DATA_W     = 16,
  parameter int WORDS      = 8,
  parameter int CNT_W      = 4,
  parameter int ADDR_W     = 6,
  parameter int REG_W      = 16,
  parameter int STATE_ADDR = 24,
  parameter int TC_ADDR    = 25,
  parameter int CNT_ADDR   = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic [DATA_W*WORDS-1:0] cap_data,
  input  logic                    chain_in_n,
  output logic                    chain_out_n,
  output logic                    ro_valid,
  output logic [DATA_W-1:0]       ro_data
);
  localparam int SEL_W = $clog2(WORDS);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_DONE} st_t;

  st_t              st;
  logic             ro_en;
  logic [CNT_W-1:0] tc, cnt;
  logic             active;
  logic             unused_wbits;

  assign active       = ro_en && (tc != '0);
  assign unused_wbits = ^reg_wdata[REG_W-2:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ro_en <= 1'b0;
      tc    <= '0;
    end else if (reg_wr && reg_addr == ADDR_W'(TC_ADDR)) begin
      ro_en <= reg_wdata[REG_W-1];
      tc    <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (active && !chain_in_n) st <= S_SEND;
        end
        S_SEND: begin
          if (chain_in_n || !active) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
            if (cnt + CNT_W'(1) == tc) st <= S_DONE;
          end
        end
        S_DONE: begin
          if (chain_in_n) begin
            st  <= S_IDLE;
            cnt <= '0;
          end
        end
        default: begin
          st  <= S_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign ro_valid    = (st == S_SEND);
  assign ro_data     = cap_data[cnt[SEL_W-1:0]*DATA_W +: DATA_W];
  assign chain_out_n = active ? (st != S_DONE) : chain_in_n;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(STATE_ADDR))
      reg_rdata[2:0] = {ro_valid, chain_out_n, chain_in_n};
    else if (reg_addr == ADDR_W'(TC_ADDR)) begin
      reg_rdata[REG_W-1]   = ro_en;
      reg_rdata[CNT_W-1:0] = tc;
    end else if (reg_addr == ADDR_W'(CNT_ADDR))
      reg_rdata[CNT_W-1:0] = cnt;
  end

  // R1: the counter rests at zero whenever the token is not held
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> cnt == '0);

  // R3: a sampled token on an armed chip starts a burst at word 0
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && active && !chain_in_n) |=> (ro_valid && cnt == '0));

  // R5: the last word hands over with the count at the terminal value
  p_handover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && active && !chain_in_n && cnt + CNT_W'(1) == tc)
      |=> (st == S_DONE && cnt == $past(tc)));

  // R6: the token is held while upstream holds, then released
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && !chain_in_n) |=> st == S_DONE);
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && chain_in_n) |=> (st == S_IDLE && cnt == '0));

  // R7: a disarmed or zero-count chip emits nothing on the next cycle
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ro_valid);

  // R9: an upstream withdrawal aborts the burst
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && chain_in_n) |=> (!ro_valid && cnt == '0 && st == S_IDLE));
endmodule

// File: tb/chain_readout_ctl_test.sv
module chain_readout_ctl_test;
  localparam time CLK = 4ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [15:0]  reg_wdata = '0;
  logic [15:0]  reg_rdata;
  logic [127:0] cap_data = '0;
  logic         chain_in_n = 1'b1;
  logic         chain_out_n;
  logic         ro_valid;
  logic [15:0]  ro_data;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_q[$];

  always #(CLK/2) clk = ~clk;

  chain_readout_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_data(cap_data),
    .chain_in_n(chain_in_n), .chain_out_n(chain_out_n),
    .ro_valid(ro_valid), .ro_data(ro_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected word per valid cycle (R3, R4)
  always @(negedge clk) begin
    if (rst_n && ro_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected word", 32'(ro_data), 32'hffff);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(ro_data == e, "R4 word order", 32'(ro_data), 32'(e));
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push_words(input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(cap_data[(k % 8)*16 +: 16]);
  endtask

  task automatic burst(input int n, input logic [127:0] snap);
    logic [15:0] d;
    cap_data = snap;
    wr(6'd25, 16'h8000 | 16'(n));
    push_words(n);
    @(posedge clk); #1; chain_in_n = 1'b0;
    @(negedge clk);
    chk(chain_out_n && !ro_valid, "R3 not started before edge", {ro_valid, chain_out_n}, 32'b01);
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(ro_valid, "R3 valid run", 32'(ro_valid), 32'd1);
      chk(chain_out_n, "R5 token held during burst", 32'(chain_out_n), 32'd1);
      if (i == 0) begin
        rd(6'd24, d);
        chk(d == 16'h0006, "R3 state during burst", 32'(d), 32'h6);
      end
      @(posedge clk);
    end
    @(negedge clk);
    chk(!ro_valid, "R3 run length", 32'(ro_valid), 32'd0);
    chk(!chain_out_n, "R5 token out after last word", 32'(chain_out_n), 32'd0);
    rd(6'd26, d);
    chk(d == 16'(n), "R5 count equals terminal", 32'(d), 32'(n));
    chk(exp_q.size() == 0, "R4 all words sent", 32'(exp_q.size()), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!chain_out_n, "R6 token held", 32'(chain_out_n), 32'd0);
    @(posedge clk); #1; chain_in_n = 1'b1;
    @(negedge clk);
    chk(!chain_out_n, "R6 still low before edge", 32'(chain_out_n), 32'd0);
    @(posedge clk); @(negedge clk);
    chk(chain_out_n, "R6 released", 32'(chain_out_n), 32'd1);
    rd(6'd26, d);
    chk(d == 16'd0, "R6 count cleared", 32'(d), 32'd0);
  endtask

  task automatic passthru(input string req);
    @(posedge clk); #1; chain_in_n = 1'b0; #1;
    chk(!chain_out_n, req, 32'(chain_out_n), 32'd0);
    repeat (4) @(posedge clk);
    #1; chain_in_n = 1'b1; #1;
    chk(chain_out_n, req, 32'(chain_out_n), 32'd1);
    @(negedge clk);
    chk(exp_q.size() == 0 && !ro_valid, req, 32'(ro_valid), 32'd0);
  endtask

  initial begin
    #(CLK*100000);
    chk(1'b0, "watchdog", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(6'd25, d); chk(d == 16'h0, "R1 terminal reg", 32'(d), 32'h0);
    rd(6'd26, d); chk(d == 16'h0, "R1 count", 32'(d), 32'h0);
    rd(6'd24, d); chk(d == 16'h3, "R1 state", 32'(d), 32'h3);
    chk(!ro_valid && chain_out_n, "R1 outputs", {ro_valid, chain_out_n}, 32'b01);

    // R2: disabled with a nonzero count
    wr(6'd25, 16'h0005);
    passthru("R2 pass-through");

    // R8: register window
    wr(6'd25, 16'hffff);
    rd(6'd25, d); chk(d == 16'h800f, "R8 masked write", 32'(d), 32'h800f);
    wr(6'd24, 16'hffff); wr(6'd26, 16'hffff);
    rd(6'd24, d); chk(d == 16'h3, "R8 state write ignored", 32'(d), 32'h3);
    rd(6'd26, d); chk(d == 16'h0, "R8 count write ignored", 32'(d), 32'h0);
    rd(6'd5, d);  chk(d == 16'h0, "R8 unmapped", 32'(d), 32'h0);

    // R3 R4 R5 R6: bursts of several lengths and patterns
    burst(3,  128'h7777_6666_5555_4444_3333_2222_1111_0000);
    burst(8,  128'hf00d_beef_cafe_1234_abcd_8001_0102_a5a5);
    burst(11, 128'h0807_0605_0403_0201_ffee_ddcc_bbaa_9988);
    burst(1,  128'hdead_0000_0000_0000_0000_0000_0000_c0de);

    // R7: enabled with zero count
    wr(6'd25, 16'h8000);
    passthru("R7 zero count pass-through");

    // R9: abort after two words
    cap_data = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    wr(6'd25, 16'h8006);
    push_words(2);
    @(posedge clk); #1; chain_in_n = 1'b0;
    @(posedge clk); @(posedge clk); #1; chain_in_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!ro_valid && chain_out_n, "R9 abort outputs", {ro_valid, chain_out_n}, 32'b01);
    rd(6'd26, d); chk(d == 16'h0, "R9 abort count", 32'(d), 32'h0);
    chk(exp_q.size() == 0, "R9 words before abort", 32'(exp_q.size()), 32'd0);
    repeat (3) @(negedge clk);
    chk(!ro_valid, "R9 stays quiet", 32'(ro_valid), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule